// File: doc/BRIEF.md
# Auto-Reload PWM Down-Timer

This block is an 8-bit down-counter with an auto-reload register and a 2-bit prescaler. It sits on a simple byte-wide register bus. It produces a square-wave output for pulse-width or frequency generation, and a level interrupt. A one-cycle base enable pulse (the 1 µs timebase) drives the prescaler. Each prescaled tick moves the count down by one. When the count passes below zero, the block does three things: it reloads the count from the auto-reload register, it can invert the waveform output, and it latches an interrupt-pending flag.

Software sets up the block through three registers:

| Address | Register | Contents |
|---|---|---|
| 0 | Count | The live count |
| 1 | Reload | The auto-reload value |
| 2 | Control | Run, toggle-enable, interrupt-enable, prescaler select and the sticky pending flag |

The half-period of the output, counted in base ticks, is (reload + 1) × prescale.

Top module: `pwm_reload_timer`

## Requirements
- R1: While the run bit (control bit 2) is 1, the count decrements once per prescaled tick. While it is 0, the count holds.
- R2: The prescaler select field (control bits 6:5) divides the base tick as follows: 00 by 1, 01 by 2, 10 by 4 and 11 by 8.
- R3: When a prescaled tick arrives with the count at 0x00, the count is loaded from the reload register. Successive output toggles are therefore (reload + 1) × prescale base ticks apart.
- R4: With toggle enable (control bit 3) set to 1, every underflow inverts `pwm_out`. With it set to 0, `pwm_out` keeps its level.
- R5: Every underflow sets the pending flag (control bit 7), whatever the toggle-enable setting. `irq` is 1 exactly when the pending flag and interrupt enable (control bit 4) are both 1.
- R6: A control write with bit 7 = 0 clears the pending flag, and a write with bit 7 = 1 leaves it unchanged. An underflow in the same cycle as a clearing write wins, and the flag stays set.
- R7: After reset the count reads 0xFF, reload reads 0x00 and control reads 0x00, with `pwm_out` = 0 and `irq` = 0.
- R8: Register addresses are 0 = count, 1 = reload and 2 = control. Address 3 reads 0x00. Control bits 1:0 read 0 and ignore writes.
- R9: When the run bit goes from 0 to 1, the prescaler restarts from zero. The first decrement therefore comes one full prescaled period after the start.
- R10: A count write takes effect on the next clock and overrides any decrement or reload in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle timebase enable (1 µs) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt |
| pwm_out | output | 1 | Toggling waveform output |

## Verification
The assertions check, on every cycle:
- the reload taken at an underflow;
- that the output moves only on an enabled underflow;
- the set, clear and sticky rules of the pending flag, including the underflow-wins case;
- that the count holds while stopped;
- that a count write overrides the counter.

Only the bench scenarios can show the following:
- the toggle spacing for each prescaler code and for several reload values;
- the one-period delay of the first decrement after a start;
- the reset values, the register map and the reserved bits seen at the bus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    localparam int B_PEND = 7;
    localparam int B_PSEL = 5;
    localparam int B_IE   = 4;
    localparam int B_TE   = 3;
    localparam int B_RUN  = 2;

    typedef struct packed {
        logic       pend;
        logic [1:0] psel;
        logic       ie;
        logic       te;
        logic       run;
    } ctrl_t;

    function automatic logic [7:0] ctrl_pack(ctrl_t c);
        return {c.pend, c.psel, c.ie, c.te, c.run, 2'b00};
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             base_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ptick
);
    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int PRE_W     = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim   = PRE_W'((32'd1 << sel) - 32'd1);
        st_d  = st_q;
        ptick = 1'b0;
        if (!run) begin
            // stopped: hold at zero so a restart begins a full period
            st_d.pre = '0;
        end else if (base_tick) begin
            if (st_q.pre >= lim) begin
                st_d.pre = '0;
                ptick    = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [tmr_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      uflow,
    output tmr_pkg::ctrl_t            ctrl,
    output logic [DATA_W-1:0]         reload
);
    import tmr_pkg::*;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] reload;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == A_RELOAD) begin
            st_d.reload = wdata;
        end
        if (wr_en && addr == A_CTRL) begin
            st_d.ctrl.psel = wdata[B_PSEL +: 2];
            st_d.ctrl.ie   = wdata[B_IE];
            st_d.ctrl.te   = wdata[B_TE];
            st_d.ctrl.run  = wdata[B_RUN];
            if (!wdata[B_PEND]) st_d.ctrl.pend = 1'b0;
        end
        // a hardware set beats a software clear in the same cycle
        if (uflow) st_d.ctrl.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl   = st_q.ctrl;
    assign reload = st_q.reload;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptick,
    input  logic              te,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] cnt,
    output logic              uflow,
    output logic              pwm
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              pwm;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        uflow = ptick && !load && (st_q.cnt == '0);
        if (load) begin
            st_d.cnt = load_val;
        end else if (ptick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload;
                if (te) st_d.pwm = ~st_q.pwm;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.pwm <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign pwm = st_q.pwm;
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              pwm_out
);
    import tmr_pkg::*;

    localparam int SEL_W = 2;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] cnt;
    logic              uflow;
    logic              ptick;
    logic              pend, ie, te, run;
    logic              cnt_wr;

    assign pend   = ctrl.pend;
    assign ie     = ctrl.ie;
    assign te     = ctrl.te;
    assign run    = ctrl.run;
    assign cnt_wr = wr_en && (addr == A_COUNT);

    tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .base_tick (base_tick),
        .sel       (ctrl.psel),
        .ptick     (ptick)
    );

    tmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .uflow  (uflow),
        .ctrl   (ctrl),
        .reload (reload)
    );

    tmr_count #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptick    (ptick),
        .te       (te),
        .load     (cnt_wr),
        .load_val (wdata),
        .reload   (reload),
        .cnt      (cnt),
        .uflow    (uflow),
        .pwm      (pwm_out)
    );

    always_comb begin
        case (addr)
            A_COUNT:  rdata = cnt;
            A_RELOAD: rdata = reload;
            A_CTRL:   rdata = DATA_W'(ctrl_pack(ctrl));
            default:  rdata = '0;
        endcase
    end

    assign irq = pend && ie;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              uflow,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] reload,
    input logic              pend,
    input logic              te,
    input logic              run,
    input logic              pwm_out
);
    import tmr_pkg::*;

    logic ctrl_clear;
    assign ctrl_clear = wr_en && (addr == A_CTRL) && !wdata[B_PEND];

    // R3
    reload_on_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> cnt == $past(reload));

    // R4
    pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(uflow && te) |=> $stable(pwm_out));

    // R4
    pwm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && te) |=> pwm_out != $past(pwm_out));

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> pend);

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_clear && !uflow) |=> !pend);

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ctrl_clear) |=> pend);

    // R1
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && addr == A_COUNT)) |=> $stable(cnt));

    // R10
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_COUNT) |=> cnt == $past(wdata));
endmodule

bind pwm_reload_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .uflow   (uflow),
    .cnt     (cnt),
    .reload  (reload),
    .pend    (pend),
    .te      (te),
    .run     (run),
    .pwm_out (pwm_out)
);

// File: tb/tb_pwm_reload_timer.sv
module tb_pwm_reload_timer;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    wire  [7:0] rdata;
    wire        irq;
    wire        pwm_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_reload_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq       (irq),
        .pwm_out   (pwm_out)
    );

    // base tick every TICK_DIV (=2) clocks
    always @(negedge clk) begin
        if (rst_n) base_tick <= ~base_tick;
        else       base_tick <= 1'b0;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_now(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // monitor: measures spacing of output edges, pops expected spacing
    initial begin
        bit last_lvl;
        bit have_prev;
        int prev_cyc;
        last_lvl  = 1'b0;
        have_prev = 1'b0;
        prev_cyc  = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!mon_on) begin
                have_prev = 1'b0;
                last_lvl  = pwm_out;
            end else if (pwm_out !== last_lvl) begin
                last_lvl = pwm_out;
                if (have_prev && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check("R2/R3/R4 toggle spacing", cyc - prev_cyc, e);
                end
                have_prev = 1'b1;
                prev_cyc  = cyc;
            end
        end
    end

    // driver: configure a reload/prescale pair, queue two expected spacings
    task automatic run_period(input int r, input int ps);
        mon_on = 1'b0;
        wr(2'd2, 8'h00);
        wr(2'd1, 8'(r));
        wr(2'd0, 8'(r));
        exp_q.push_back((r + 1) * (1 << ps) * TICK_DIV);
        exp_q.push_back((r + 1) * (1 << ps) * TICK_DIV);
        mon_on = 1'b1;
        wr(2'd2, 8'(ps << 5) | 8'h0C);
        while (exp_q.size() > 0) @(negedge clk);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        bit         p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        rd_now(2'd0, v); check("R7 count reset", v, 8'hFF);
        rd_now(2'd1, v); check("R7 reload reset", v, 8'h00);
        rd_now(2'd2, v); check("R7 control reset", v, 8'h00);
        check("R7 pwm reset", pwm_out, 0);
        check("R7 irq reset", irq, 0);

        // R8 register map and reserved bits
        wr(2'd1, 8'h5A);
        rd_now(2'd1, v); check("R8 reload readback", v, 8'h5A);
        wr(2'd2, 8'h7B);
        rd_now(2'd2, v); check("R8 control reserved bits", v, 8'h78);
        rd_now(2'd3, v); check("R8 unmapped address", v, 8'h00);
        wr(2'd2, 8'h00);

        // R2 R3 R4 periods over all prescaler codes
        run_period(3, 0);
        run_period(3, 1);
        run_period(1, 2);
        run_period(0, 3);
        run_period(10, 0);
        run_period(5, 3);

        // R5 R6 pending flag and interrupt gating
        wr(2'd2, 8'h80);
        rd_now(2'd2, v); check("R6 writing 1 keeps pending", v, 8'h80);
        check("R5 irq masked", irq, 0);
        wr(2'd2, 8'h90);
        check("R5 irq pending and enabled", irq, 1);
        wr(2'd2, 8'h10);
        check("R6 clear drops irq", irq, 0);
        rd_now(2'd2, v); check("R6 cleared flag", v, 8'h10);
        wr(2'd2, 8'h90);
        rd_now(2'd2, v); check("R6 writing 1 does not set", v, 8'h10);

        // R4 toggle disabled holds pin; R5 flag still sets
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        p0 = pwm_out;
        wr(2'd2, 8'h04);
        repeat (40) @(negedge clk);
        check("R4 pin holds with toggle off", pwm_out, p0);
        rd_now(2'd2, v); check("R5 underflow sets pending", v[7], 1);
        wr(2'd2, 8'h00);

        // R1 run decrements, stop holds
        wr(2'd0, 8'd100);
        wr(2'd2, 8'h04);
        repeat (20) @(negedge clk);
        wr(2'd2, 8'h00);
        rd_now(2'd0, v);
        check("R1 count decremented", (v < 8'd100) ? 1 : 0, 1);
        repeat (10) @(negedge clk);
        rd_now(2'd0, v2);
        check("R1 count holds when stopped", v2, v);

        // R9 first decrement one full prescaled period after start
        wr(2'd0, 8'd50);
        wr(2'd2, 8'h64);
        repeat (11) @(negedge clk);
        rd_now(2'd0, v); check("R9 no early decrement", v, 50);
        repeat (8) @(negedge clk);
        rd_now(2'd0, v); check("R9 first decrement", v, 49);
        wr(2'd2, 8'h00);

        // R10 count write overrides decrement
        wr(2'd1, 8'd200);
        wr(2'd2, 8'h04);
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, 8'(30 + 7 * i));
            rd_now(2'd0, v);
            check("R10 count write wins", v, 30 + 7 * i);
        end
        wr(2'd2, 8'h00);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule